// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master. From one programmable clock control count it derives the length of the low phase and the high phase of SCL, in peripheral clock cycles. A speed-mode bit and a duty bit pick the ratio between the two phases. It drives SCL as an open-drain output: it either pulls the line low or releases it. It also watches the real line level, so a slave that holds SCL low stretches the clock.

The block emits two single-cycle strobes for a byte engine. One marks the cycle in which SCL is released, so data can be sampled. The other marks the cycle in which SCL is pulled low, so data can change. A rise-time allowance, written by software as the clock frequency in MHz plus one for standard mode, or that frequency times 0.3 plus one for fast mode, sets how many cycles of the high phase may pass before the line is seen high. The sensed line level reaches the phase logic through a two-stage synchronizer.

The configuration inputs must be held stable while the block is enabled. They are registered once before use.

Top module: `scl_clk_gen`

## Requirements
- R1: In standard mode (fast_mode=0) the low phase and the high phase of SCL each last max(ccr_count,4) clock cycles, and duty_16_9 has no effect.
- R2: In standard mode a ccr_count below 4 (0 to 3) gives the same phase lengths as a ccr_count of 4.
- R3: In fast mode with duty_16_9=0 the low phase lasts 2*C and the high phase lasts C cycles, where C = max(ccr_count,1).
- R4: In fast mode with duty_16_9=1 the low phase lasts 16*C and the high phase lasts 9*C cycles, where C = max(ccr_count,1).
- R5: In fast mode a ccr_count of 0 is treated as 1.
- R6: While enable is 0, scl_drive_low is 0 and neither strobe fires, from the cycle after enable falls. When enable rises, the next cycle is the first low cycle of a fresh period.
- R7: tick_fall is 1 for exactly the first cycle of each low phase, and tick_rise is 1 for exactly the first cycle of each high phase. The two strobes are never 1 together.
- R8: The high phase is counted only in the first rise_count cycles after release, or in cycles where the synchronized line is high. If the line stays low for D cycles after release, the high phase lasts H + D + 2 - rise_count cycles, where H is its nominal length, whenever rise_count < H and rise_count < D + 2.
- R9: If rise_count >= D + 2, or rise_count >= H, the high phase keeps its nominal length H.
- R10: During and after reset, with enable low, scl_drive_low, tick_rise and tick_fall are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the clock; 0 releases SCL and clears all counters |
| ccr_count | input | CCR_W | Clock control count |
| fast_mode | input | 1 | 1 = fast mode, 0 = standard mode |
| duty_16_9 | input | 1 | Fast-mode ratio: 1 = 16:9, 0 = 2:1 |
| rise_count | input | RISE_W | Rise-time allowance in clock cycles |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release it |
| tick_rise | output | 1 | One-cycle strobe in the first released cycle |
| tick_fall | output | 1 | One-cycle strobe in the first driven-low cycle |

## Verification
Enable is sampled at one clock edge. The first tick_fall appears in the cycle after that edge. Each later strobe is due exactly one phase length after the one before it. A stretched high phase is due D + 2 - rise_count cycles later, because of the two synchronizer stages. The driver turns each configuration into a list of strobes, each tagged with the absolute cycle number it is due in, and puts the list in a queue. The monitor samples on the falling clock edge and counts rising edges. Each strobe must match the head of the queue in kind and in cycle, and must show the matching drive level. A strobe that is late, early, repeated or unexpected is therefore reported.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } scl_phase_t;

   localparam int unsigned STD_FLOOR  = 4;
   localparam int unsigned FAST_FLOOR = 1;

endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len #(
   parameter int unsigned CCR_W        = 12,
   parameter bit          HAS_DUTY_169 = 1'b1,
   localparam int unsigned LEN_W       = CCR_W + 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CCR_W-1:0] ccr_count,
   input  logic             fast_mode,
   input  logic             duty_16_9,
   output logic [LEN_W-1:0] low_len,
   output logic [LEN_W-1:0] high_len
);
   import scl_gen_pkg::*;

   logic [LEN_W-1:0] std_eff;
   logic [LEN_W-1:0] fast_eff;
   logic [LEN_W-1:0] low_d;
   logic [LEN_W-1:0] high_d;
   logic             use_169;

   always_comb begin
      std_eff  = LEN_W'(ccr_count);
      if (ccr_count < CCR_W'(STD_FLOOR)) std_eff = LEN_W'(STD_FLOOR);
      fast_eff = LEN_W'(ccr_count);
      if (ccr_count < CCR_W'(FAST_FLOOR)) fast_eff = LEN_W'(FAST_FLOOR);
   end

   generate
      if (HAS_DUTY_169) begin : g_duty_sel
         assign use_169 = duty_16_9;
      end else begin : g_duty_fixed
         assign use_169 = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!fast_mode) begin
         low_d  = std_eff;
         high_d = std_eff;
      end else if (use_169) begin
         low_d  = fast_eff << 4;
         high_d = (fast_eff << 3) + fast_eff;
      end else begin
         low_d  = fast_eff << 1;
         high_d = fast_eff;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_len  <= LEN_W'(STD_FLOOR);
         high_len <= LEN_W'(STD_FLOOR);
      end else begin
         low_len  <= low_d;
         high_len <= high_d;
      end
   end

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_sync
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= line_in;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[STAGES-2:0], line_in};
         end
      end
   endgenerate

   assign line_sync = sr[STAGES-1];

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
   parameter int unsigned LEN_W  = 17,
   parameter int unsigned RISE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [LEN_W-1:0]  low_len,
   input  logic [LEN_W-1:0]  high_len,
   input  logic [RISE_W-1:0] rise_count,
   input  logic              line_high,
   output logic              scl_low,
   output logic              tick_rise,
   output logic              tick_fall
);
   import scl_gen_pkg::*;

   scl_phase_t        phase_q, phase_d;
   logic [LEN_W-1:0]  cnt_q, cnt_d;
   logic [RISE_W-1:0] rcnt_q, rcnt_d;
   logic              low_q, low_d;
   logic              trise_d, tfall_d;
   logic              advance;

   assign advance = line_high || (rcnt_q < rise_count);

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      rcnt_d  = rcnt_q;
      low_d   = low_q;
      trise_d = 1'b0;
      tfall_d = 1'b0;
      if (!enable) begin
         phase_d = PH_IDLE;
         cnt_d   = '0;
         rcnt_d  = '0;
         low_d   = 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               phase_d = PH_LOW;
               cnt_d   = '0;
               low_d   = 1'b1;
               tfall_d = 1'b1;
            end
            PH_LOW: begin
               if (cnt_q == low_len - 1'b1) begin
                  phase_d = PH_HIGH;
                  cnt_d   = '0;
                  rcnt_d  = '0;
                  low_d   = 1'b0;
                  trise_d = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            PH_HIGH: begin
               if (rcnt_q != '1) rcnt_d = rcnt_q + 1'b1;
               if (advance) begin
                  if (cnt_q == high_len - 1'b1) begin
                     phase_d = PH_LOW;
                     cnt_d   = '0;
                     low_d   = 1'b1;
                     tfall_d = 1'b1;
                  end else begin
                     cnt_d = cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               phase_d = PH_IDLE;
               cnt_d   = '0;
               low_d   = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         rcnt_q    <= '0;
         low_q     <= 1'b0;
         tick_rise <= 1'b0;
         tick_fall <= 1'b0;
      end else begin
         phase_q   <= phase_d;
         cnt_q     <= cnt_d;
         rcnt_q    <= rcnt_d;
         low_q     <= low_d;
         tick_rise <= trise_d;
         tick_fall <= tfall_d;
      end
   end

   assign scl_low = low_q;

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen #(
   parameter int unsigned CCR_W        = 12,
   parameter int unsigned RISE_W       = 6,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          HAS_DUTY_169 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [CCR_W-1:0]  ccr_count,
   input  logic              fast_mode,
   input  logic              duty_16_9,
   input  logic [RISE_W-1:0] rise_count,
   input  logic              scl_in,
   output logic              scl_drive_low,
   output logic              tick_rise,
   output logic              tick_fall
);
   localparam int unsigned LEN_W = CCR_W + 5;

   generate
      if (CCR_W < 3) begin : g_bad_ccr
         $error("scl_clk_gen: CCR_W must be at least 3");
      end
      if (RISE_W < 1) begin : g_bad_rise
         $error("scl_clk_gen: RISE_W must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("scl_clk_gen: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [LEN_W-1:0] low_len;
   logic [LEN_W-1:0] high_len;
   logic             line_high;

   scl_phase_len #(
      .CCR_W        (CCR_W),
      .HAS_DUTY_169 (HAS_DUTY_169)
   ) i_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .ccr_count (ccr_count),
      .fast_mode (fast_mode),
      .duty_16_9 (duty_16_9),
      .low_len   (low_len),
      .high_len  (high_len)
   );

   scl_line_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (scl_in),
      .line_sync (line_high)
   );

   scl_phase_fsm #(
      .LEN_W  (LEN_W),
      .RISE_W (RISE_W)
   ) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .low_len    (low_len),
      .high_len   (high_len),
      .rise_count (rise_count),
      .line_high  (line_high),
      .scl_low    (scl_drive_low),
      .tick_rise  (tick_rise),
      .tick_fall  (tick_fall)
   );

endmodule

// File: rtl/scl_clk_gen_chk.sv
module scl_clk_gen_chk #(
   parameter int unsigned CW = 20
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic fast_mode,
   input logic scl_drive_low,
   input logic tick_rise,
   input logic tick_fall
);
   logic [CW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        low_run <= '0;
      else if (tick_fall)                low_run <= CW'(1);
      else if (scl_drive_low && low_run != '1) low_run <= low_run + 1'b1;
   end

   AST_TICKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_rise && tick_fall)); // R7

   AST_RISE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_rise |-> !scl_drive_low); // R7

   AST_FALL_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      tick_fall |-> scl_drive_low); // R7

   AST_DRIVE_START_TICKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> tick_fall); // R7

   AST_RELEASE_TICKED: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_drive_low) && $past(enable)) |-> tick_rise); // R7

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_drive_low && !tick_rise && !tick_fall)); // R6

   AST_STD_LOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_rise && !fast_mode) |-> (low_run >= CW'(4))); // R2

   AST_FAST_LOW_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_rise && fast_mode) |-> (low_run >= CW'(2))); // R5

endmodule

bind scl_clk_gen scl_clk_gen_chk #(.CW(CCR_W + 6)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable        (enable),
   .fast_mode     (fast_mode),
   .scl_drive_low (scl_drive_low),
   .tick_rise     (tick_rise),
   .tick_fall     (tick_fall)
);

// File: tb/test_scl_clk_gen.sv
module test_scl_clk_gen;
   localparam int CCR_W  = 12;
   localparam int RISE_W = 6;
   localparam int SYNC_LAT = 2;

   typedef struct {
      bit          is_rise;
      int unsigned cyc;
      string       tag;
   } exp_evt_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enable = 1'b0;
   logic [CCR_W-1:0]  ccr_count = '0;
   logic              fast_mode = 1'b0;
   logic              duty_16_9 = 1'b0;
   logic [RISE_W-1:0] rise_count = '0;
   logic              scl_in;
   logic              scl_drive_low;
   logic              tick_rise;
   logic              tick_fall;

   int unsigned cyc = 0;
   int          n_vec = 0;
   int          n_bad = 0;
   int          slave_dly = 0;
   int          hold_cnt = 0;
   bit          done = 1'b0;
   exp_evt_t    expq[$];

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      if (scl_drive_low)      hold_cnt <= slave_dly;
      else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1;
   end
   assign scl_in = !scl_drive_low && (hold_cnt == 0);

   scl_clk_gen #(.CCR_W(CCR_W), .RISE_W(RISE_W)) i_scl_clk_gen (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .ccr_count     (ccr_count),
      .fast_mode     (fast_mode),
      .duty_16_9     (duty_16_9),
      .rise_count    (rise_count),
      .scl_in        (scl_in),
      .scl_drive_low (scl_drive_low),
      .tick_rise     (tick_rise),
      .tick_fall     (tick_fall)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every strobe
   always @(negedge clk) begin
      if (rst_n && !done && (tick_rise || tick_fall)) begin
         if (expq.size() == 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL R7 unexpected strobe: actual rise=%0d fall=%0d at cycle %0d expected none",
                     tick_rise, tick_fall, cyc);
         end else begin
            exp_evt_t e;
            e = expq.pop_front();
            check({e.tag, " strobe kind"}, int'(tick_rise), int'(e.is_rise));
            check({e.tag, " strobe cycle"}, int'(cyc), int'(e.cyc));
            check({e.tag, " drive level R7"}, int'(scl_drive_low), int'(!e.is_rise));
         end
      end
   end

   function automatic int low_nom(int c, bit f, bit d);
      int e;
      if (!f) return (c < 4) ? 4 : c;
      e = (c < 1) ? 1 : c;
      return d ? 16 * e : 2 * e;
   endfunction

   function automatic int high_nom(int c, bit f, bit d);
      int e;
      if (!f) return (c < 4) ? 4 : c;
      e = (c < 1) ? 1 : c;
      return d ? 9 * e : e;
   endfunction

   task automatic run_case(input string tag, input int c, input bit f, input bit d,
                           input int r, input int dly, input int nbits);
      int L, H, hb, base, last_rise;
      L  = low_nom(c, f, d);
      hb = high_nom(c, f, d);
      if (r >= hb || r >= dly + SYNC_LAT) H = hb;
      else                                H = hb + dly + SYNC_LAT - r;
      @(negedge clk);
      ccr_count  = CCR_W'(c);
      fast_mode  = f;
      duty_16_9  = d;
      rise_count = RISE_W'(r);
      slave_dly  = dly;
      base = cyc + 1;
      last_rise = 0;
      for (int i = 0; i < nbits; i++) begin
         expq.push_back('{1'b0, base, tag});
         expq.push_back('{1'b1, base + L, tag});
         last_rise = base + L;
         base = base + L + H;
      end
      enable = 1'b1;
      while (cyc < last_rise) @(negedge clk);
      enable = 1'b0;
      repeat (3) @(negedge clk);
      check({tag, " queue drained"}, expq.size(), 0);
      check("R6 released after disable", int'(scl_drive_low), 0);
      expq.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10 drive in reset", int'(scl_drive_low), 0);
      check("R10 rise strobe in reset", int'(tick_rise), 0);
      check("R10 fall strobe in reset", int'(tick_fall), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 idle after reset", int'(scl_drive_low | tick_rise | tick_fall), 0);

      run_case("R1 std c6",              6, 1'b0, 1'b0, 10, 0, 3);
      run_case("R1 std c6 duty ignored", 6, 1'b0, 1'b1, 10, 0, 3);
      run_case("R2 std c2 floored",      2, 1'b0, 1'b0, 10, 0, 3);
      run_case("R2 std c0 floored",      0, 1'b0, 1'b1, 10, 0, 2);
      run_case("R3 fast 2:1 c3",         3, 1'b1, 1'b0, 10, 0, 3);
      run_case("R4 fast 16:9 c2",        2, 1'b1, 1'b1, 40, 0, 2);
      run_case("R5 fast 2:1 c0",         0, 1'b1, 1'b0, 10, 0, 3);
      run_case("R5 fast 16:9 c0",        0, 1'b1, 1'b1, 10, 0, 2);
      run_case("R8 stretch std",         8, 1'b0, 1'b0, 2, 6, 3);
      run_case("R8 no allowance",        8, 1'b0, 1'b0, 0, 0, 2);
      run_case("R8 stretch fast",        2, 1'b1, 1'b0, 1, 4, 3);
      run_case("R9 allowance covers",    8, 1'b0, 1'b0, 5, 3, 3);
      run_case("R9 allowance over high", 2, 1'b1, 1'b0, 3, 9, 2);
      run_case("R6 restart after idle",  5, 1'b0, 1'b0, 10, 0, 2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule